// File: doc/BRIEF.md
# Eight-tap subpixel horizontal interpolator

This block is a pipelined filter for one image row at a time. Each transfer carries 15 unsigned 8-bit pixels and a 4-bit subpixel phase. The block returns 8 interpolated 8-bit pixels. Output column c is a weighted sum of the eight input pixels c through c+7. Input pixel 0 lies three columns left of output column 0, so the filter window overhangs by three pixels on the left and four on the right. The weights are signed and come from a built-in bank of 16 coefficient sets, one for each phase. The sum is rounded to nearest, scaled down by 128 and clamped to the 8-bit range.

The datapath has three register stages: products, adder tree, and a rounded and clamped output register. It can accept one row every cycle. Both sides use a valid/ready handshake. A single advance condition moves all stages together, so a stalled output freezes the whole pipe. The output register is governed by a two-state slot machine:
- `SLOT_EMPTY` moves to `SLOT_HELD` ("fill") when a valid row leaves the adder stage.
- `SLOT_HELD` moves to `SLOT_EMPTY` ("drain") when the consumer accepts and no row follows.
- `SLOT_HELD` stays in `SLOT_HELD` in two cases: it is stalled ("hold") when the consumer is not ready, or it loads the next row in the same cycle ("replace").

Top module: `subpel_hfilt8`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: Input pixel j occupies `in_pixels[8j+7:8j]`, output column c occupies `out_pixels[8c+7:8c]`, and before rounding column c equals sum over t=0..7 of w(phase,t)*pixel[c+t]. The weight rows w(p,0..7) for phases 1 to 8 are: p1 {0,1,-5,126,8,-3,1,0}; p2 {-1,3,-10,122,18,-6,2,0}; p3 {-1,4,-13,118,27,-9,3,-1}; p4 {-1,4,-16,112,37,-11,4,-1}; p5 {-1,5,-18,105,48,-14,4,-1}; p6 {-1,5,-19,97,58,-16,5,-1}; p7 {-1,6,-19,88,68,-18,5,-1}; p8 {-1,6,-19,78,78,-19,6,-1}. For phases 9 to 15, w(p,t) = w(16-p,7-t). The magnitude of the pre-rounding sum stays below 65536.
- R3: The pre-rounding sum s becomes floor((s+64)/128), an arithmetic shift right by 7. Exact halves round upward.
- R4: A rounded value below 0 gives output 0, and a rounded value above 255 gives output 255.
- R5: A row whose 15 pixels all equal v produces v in all 8 columns, for every phase.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_pixels` do not change.
- R7: `in_ready` is 0 exactly when `out_valid` is 1 and `out_ready` is 0. Every accepted row produces exactly one output row, in acceptance order.
- R8: With `out_ready` held at 1, a row accepted at clock edge N is presented after edge N+2, and back-to-back rows come out on consecutive cycles.
- R9: Phase 0 is a pure copy: output column c equals input pixel c+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A row and phase are offered |
| in_ready | output | 1 | The row is taken at this edge when valid |
| in_pixels | input | 120 | 15 source pixels, pixel j in bits 8j+7:8j |
| in_phase | input | 4 | Subpixel phase 0..15 |
| out_valid | output | 1 | Filtered row is available |
| out_ready | input | 1 | Consumer takes the row at this edge |
| out_pixels | output | 64 | 8 filtered pixels, column c in bits 8c+7:8c |

## Verification
Four properties are checked on every cycle:
- a stalled output keeps its data and valid flag;
- the input side is refused while the output is stalled;
- the adder-tree sums stay inside the bound that the coefficient bank implies;
- a row whose column-0 sum is negative, or at or above the saturation threshold, leaves 0 or 255 in that column.

The numeric result of every column, the coefficient rows themselves, the copy behaviour of phase 0, the three-cycle latency, full throughput, and lossless ordering under random backpressure can be shown only by the bench's scenarios. The bench compares each output row against its own model of the weighted sum.

// File: rtl/subpel_hfilt8_pkg.sv
`timescale 1ns/1ps
package subpel_hfilt8_pkg;

    localparam int COEF_W  = 16;
    localparam int PHASE_W = 4;

    typedef logic signed [COEF_W-1:0] coef_t;

    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_HELD  = 1'b1
    } slot_state_e;

    // Weight rows for phases 1..8; phases 9..15 mirror them.
    function automatic int half_bank(int p, int t);
        int row [8];
        case (p)
            1:       row = '{ 0, 1,  -5, 126,   8,  -3, 1,  0};
            2:       row = '{-1, 3, -10, 122,  18,  -6, 2,  0};
            3:       row = '{-1, 4, -13, 118,  27,  -9, 3, -1};
            4:       row = '{-1, 4, -16, 112,  37, -11, 4, -1};
            5:       row = '{-1, 5, -18, 105,  48, -14, 4, -1};
            6:       row = '{-1, 5, -19,  97,  58, -16, 5, -1};
            7:       row = '{-1, 6, -19,  88,  68, -18, 5, -1};
            8:       row = '{-1, 6, -19,  78,  78, -19, 6, -1};
            default: row = '{default: 0};
        endcase
        return row[t[2:0]];
    endfunction

    // Coefficient for a phase and tap; phase 0 copies the centre pixel.
    function automatic coef_t coef_of(logic [PHASE_W-1:0] ph, int tap);
        int p;
        int v;
        p = int'(ph);
        if (p == 0)
            v = (tap == 3) ? 128 : 0;
        else if (p <= 8)
            v = half_bank(p, tap);
        else
            v = half_bank(16 - p, 7 - tap);
        return coef_t'(v);
    endfunction

endpackage

// File: rtl/hf_coef_bank.sv
`timescale 1ns/1ps
module hf_coef_bank
    import subpel_hfilt8_pkg::*;
#(
    parameter int TAPS = 8
) (
    input  logic [PHASE_W-1:0]     phase,
    output logic [TAPS*COEF_W-1:0] coefs
);

    for (genvar t = 0; t < TAPS; t++) begin : g_tap
        assign coefs[t*COEF_W +: COEF_W] = coef_of(phase, t);
    end

endmodule

// File: rtl/hf_mult_stage.sv
`timescale 1ns/1ps
module hf_mult_stage
    import subpel_hfilt8_pkg::*;
#(
    parameter int TAPS     = 8,
    parameter int OUT_COLS = 8,
    parameter int PIX_W    = 8
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 adv,
    input  logic                                 in_valid,
    input  logic [(OUT_COLS+TAPS-1)*PIX_W-1:0]   pixels,
    input  logic [TAPS*COEF_W-1:0]               coefs,
    output logic                                 prod_valid,
    output logic [OUT_COLS*TAPS*(COEF_W+PIX_W+1)-1:0] prods
);

    localparam int PROD_W = COEF_W + PIX_W + 1;
    localparam int NPROD  = OUT_COLS * TAPS;

    logic signed [PROD_W-1:0] prod_d [NPROD];
    logic signed [PROD_W-1:0] prod_q [NPROD];

    for (genvar c = 0; c < OUT_COLS; c++) begin : g_col
        for (genvar t = 0; t < TAPS; t++) begin : g_tap
            logic signed [COEF_W-1:0] cf;
            logic signed [PIX_W:0]    px;
            assign cf = coefs[t*COEF_W +: COEF_W];
            assign px = {1'b0, pixels[(c+t)*PIX_W +: PIX_W]};
            assign prod_d[c*TAPS+t] = PROD_W'(cf) * PROD_W'(px);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            prod_valid <= 1'b0;
        else if (adv)
            prod_valid <= in_valid;
    end

    always_ff @(posedge clk) begin
        if (adv && in_valid) begin
            for (int i = 0; i < NPROD; i++)
                prod_q[i] <= prod_d[i];
        end
    end

    for (genvar i = 0; i < NPROD; i++) begin : g_out
        assign prods[i*PROD_W +: PROD_W] = prod_q[i];
    end

endmodule

// File: rtl/hf_sum_stage.sv
`timescale 1ns/1ps
module hf_sum_stage
    import subpel_hfilt8_pkg::*;
#(
    parameter int TAPS     = 8,
    parameter int OUT_COLS = 8,
    parameter int PIX_W    = 8,
    parameter int ACC_W    = 32
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      adv,
    input  logic                                      prod_valid,
    input  logic [OUT_COLS*TAPS*(COEF_W+PIX_W+1)-1:0] prods,
    output logic                                      sum_valid,
    output logic [OUT_COLS*ACC_W-1:0]                 sums
);

    localparam int PROD_W  = COEF_W + PIX_W + 1;
    localparam int SUM_LIM = 1 << (2 * PIX_W);

    logic signed [ACC_W-1:0] sum_d [OUT_COLS];
    logic signed [ACC_W-1:0] sum_q [OUT_COLS];

    for (genvar c = 0; c < OUT_COLS; c++) begin : g_col
        // Heap-ordered tree: leaves at TAPS..2*TAPS-1, root at 1.
        logic signed [ACC_W-1:0] node [1:2*TAPS-1];
        for (genvar t = 0; t < TAPS; t++) begin : g_leaf
            assign node[TAPS+t] =
                ACC_W'($signed(prods[(c*TAPS+t)*PROD_W +: PROD_W]));
        end
        for (genvar n = 1; n < TAPS; n++) begin : g_node
            assign node[n] = node[2*n] + node[2*n+1];
        end
        assign sum_d[c] = node[1];
        assign sums[c*ACC_W +: ACC_W] = sum_q[c];

        // R2: bank gain is below 256, so sums stay within 2^(2*PIX_W)
        assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
            sum_valid |-> (sum_q[c] < SUM_LIM && sum_q[c] > -SUM_LIM));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sum_valid <= 1'b0;
        else if (adv)
            sum_valid <= prod_valid;
    end

    always_ff @(posedge clk) begin
        if (adv && prod_valid) begin
            for (int c = 0; c < OUT_COLS; c++)
                sum_q[c] <= sum_d[c];
        end
    end

endmodule

// File: rtl/hf_round_clamp.sv
`timescale 1ns/1ps
module hf_round_clamp #(
    parameter int OUT_COLS    = 8,
    parameter int PIX_W       = 8,
    parameter int ACC_W       = 32,
    parameter int ROUND_SHIFT = 7
) (
    input  logic [OUT_COLS*ACC_W-1:0] sums,
    output logic [OUT_COLS*PIX_W-1:0] pix
);

    localparam logic signed [ACC_W-1:0] RND_ADD = ACC_W'(1 << (ROUND_SHIFT - 1));
    localparam logic signed [ACC_W-1:0] SAT_HI  = ACC_W'((1 << PIX_W) - 1);

    for (genvar c = 0; c < OUT_COLS; c++) begin : g_col
        logic signed [ACC_W-1:0] s;
        logic signed [ACC_W-1:0] r;
        assign s = $signed(sums[c*ACC_W +: ACC_W]);
        assign r = (s + RND_ADD) >>> ROUND_SHIFT;
        always_comb begin
            if (r < 0)
                pix[c*PIX_W +: PIX_W] = '0;
            else if (r > SAT_HI)
                pix[c*PIX_W +: PIX_W] = '1;
            else
                pix[c*PIX_W +: PIX_W] = r[PIX_W-1:0];
        end
    end

endmodule

// File: rtl/subpel_hfilt8.sv
`timescale 1ns/1ps
module subpel_hfilt8
    import subpel_hfilt8_pkg::*;
#(
    parameter int PIX_W       = 8,
    parameter int TAPS        = 8,
    parameter int OUT_COLS    = 8,
    parameter int ACC_W       = 32,
    parameter int ROUND_SHIFT = 7
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                in_valid,
    output logic                                in_ready,
    input  logic [(OUT_COLS+TAPS-1)*PIX_W-1:0]  in_pixels,
    input  logic [PHASE_W-1:0]                  in_phase,
    output logic                                out_valid,
    input  logic                                out_ready,
    output logic [OUT_COLS*PIX_W-1:0]           out_pixels
);

    localparam int PROD_W   = COEF_W + PIX_W + 1;
    localparam int HI_LIMIT = (((1 << PIX_W) - 1) << ROUND_SHIFT) - (1 << (ROUND_SHIFT - 1));

    slot_state_e                        slot_q, slot_d;
    logic                               adv;
    logic [TAPS*COEF_W-1:0]             coefs;
    logic                               prod_valid;
    logic [OUT_COLS*TAPS*PROD_W-1:0]    prods;
    logic                               sum_valid;
    logic [OUT_COLS*ACC_W-1:0]          sums;
    logic [OUT_COLS*PIX_W-1:0]          clamped;
    logic [OUT_COLS*PIX_W-1:0]          out_q;

    // Whole pipe moves unless the output slot is full and not taken.
    assign adv = (slot_q == SLOT_EMPTY) || out_ready;

    hf_coef_bank #(.TAPS(TAPS)) u_bank (
        .phase (in_phase),
        .coefs (coefs)
    );

    hf_mult_stage #(.TAPS(TAPS), .OUT_COLS(OUT_COLS), .PIX_W(PIX_W)) u_mult (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv        (adv),
        .in_valid   (in_valid),
        .pixels     (in_pixels),
        .coefs      (coefs),
        .prod_valid (prod_valid),
        .prods      (prods)
    );

    hf_sum_stage #(.TAPS(TAPS), .OUT_COLS(OUT_COLS), .PIX_W(PIX_W), .ACC_W(ACC_W)) u_sum (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv        (adv),
        .prod_valid (prod_valid),
        .prods      (prods),
        .sum_valid  (sum_valid),
        .sums       (sums)
    );

    hf_round_clamp #(.OUT_COLS(OUT_COLS), .PIX_W(PIX_W), .ACC_W(ACC_W),
                     .ROUND_SHIFT(ROUND_SHIFT)) u_rnd (
        .sums (sums),
        .pix  (clamped)
    );

    // State register of the output slot.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            slot_q <= SLOT_EMPTY;
        else
            slot_q <= slot_d;
    end

    // Transitions: fill, drain, hold, replace.
    always_comb begin
        slot_d = slot_q;
        unique case (slot_q)
            SLOT_EMPTY: if (sum_valid) slot_d = SLOT_HELD;
            SLOT_HELD:  if (out_ready && !sum_valid) slot_d = SLOT_EMPTY;
            default:    slot_d = SLOT_EMPTY;
        endcase
    end

    // Outputs of the slot machine.
    always_comb begin
        out_valid = (slot_q == SLOT_HELD);
        in_ready  = adv;
    end

    always_ff @(posedge clk) begin
        if (adv && sum_valid)
            out_q <= clamped;
    end

    assign out_pixels = out_q;

    // R6: stalled output keeps valid and data
    assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_pixels)));

    // R7: no row is taken while the output is stalled
    assert_stall_refuse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    // R4: negative column-0 sum saturates to zero
    assert_clamp_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sum_valid && adv && ($signed(sums[ACC_W-1:0]) < 0))
        |=> (out_pixels[PIX_W-1:0] == '0));

    // R4: column-0 sum at or above threshold saturates to full scale
    assert_clamp_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sum_valid && adv && ($signed(sums[ACC_W-1:0]) >= HI_LIMIT))
        |=> (out_pixels[PIX_W-1:0] == '1));

endmodule

// File: tb/subpel_hfilt8_test.sv
`timescale 1ns/1ps
module subpel_hfilt8_test;

    localparam int IN_W  = 120;
    localparam int OUT_W = 64;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic             out_ready = 1'b0;
    logic [IN_W-1:0]  in_pixels = '0;
    logic [3:0]       in_phase = '0;
    logic             in_ready;
    logic             out_valid;
    logic [OUT_W-1:0] out_pixels;

    always #2 clk = ~clk;

    subpel_hfilt8 uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_pixels  (in_pixels),
        .in_phase   (in_phase),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_pixels (out_pixels)
    );

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int last_lat = 0;
    int last_take_cyc = 0;
    logic [OUT_W-1:0] last_take_data;
    logic             hold_pend = 1'b0;
    logic [OUT_W-1:0] hold_data;

    logic [OUT_W-1:0] exp_q [$];
    string            tag_q [$];
    int               acc_q [$];

    int base_tab [1:8][0:7] = '{
        '{ 0, 1,  -5, 126,   8,  -3, 1,  0},
        '{-1, 3, -10, 122,  18,  -6, 2,  0},
        '{-1, 4, -13, 118,  27,  -9, 3, -1},
        '{-1, 4, -16, 112,  37, -11, 4, -1},
        '{-1, 5, -18, 105,  48, -14, 4, -1},
        '{-1, 5, -19,  97,  58, -16, 5, -1},
        '{-1, 6, -19,  88,  68, -18, 5, -1},
        '{-1, 6, -19,  78,  78, -19, 6, -1}
    };

    function automatic int bank(int p, int t);
        if (p == 0) return (t == 3) ? 128 : 0;
        if (p <= 8) return base_tab[p][t];
        return base_tab[16-p][7-t];
    endfunction

    function automatic logic [OUT_W-1:0] model(logic [IN_W-1:0] row, int p);
        logic [OUT_W-1:0] res;
        for (int c = 0; c < 8; c++) begin
            int s;
            s = 0;
            for (int t = 0; t < 8; t++)
                s += bank(p, t) * int'(row[(c+t)*8 +: 8]);
            s = (s + 64) >>> 7;
            if (s < 0) s = 0;
            if (s > 255) s = 255;
            res[c*8 +: 8] = s[7:0];
        end
        return res;
    endfunction

    function automatic logic [IN_W-1:0] gen_row();
        logic [IN_W-1:0] r;
        int mode;
        mode = int'($urandom % 8);
        for (int j = 0; j < 15; j++) begin
            case (mode)
                0:       r[j*8 +: 8] = 8'h00;
                1:       r[j*8 +: 8] = 8'hFF;
                2:       r[j*8 +: 8] = ($urandom % 2) ? 8'hFF : 8'h00;
                default: r[j*8 +: 8] = 8'($urandom);
            endcase
        end
        return r;
    endfunction

    task automatic check_vec(string tag, logic [OUT_W-1:0] got, logic [OUT_W-1:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic check_int(string tag, int got, int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
        end
    endtask

    // One cycle: drive at negedge, sample after settling, book transfers
    // that the next rising edge performs.
    task automatic step(logic iv, logic [IN_W-1:0] row, logic [3:0] ph, logic ordy,
                        string tag, logic use_exp, logic [OUT_W-1:0] expv);
        @(negedge clk);
        in_valid  = iv;
        in_pixels = row;
        in_phase  = ph;
        out_ready = ordy;
        #0.5;
        cyc++;
        if (hold_pend) begin
            check_int("R6 valid held", int'(out_valid), 1);
            check_vec("R6 data held", out_pixels, hold_data);
        end
        if (out_valid && !out_ready)
            check_int("R7 in_ready low on stall", int'(in_ready), 0);
        if (iv && in_ready) begin
            exp_q.push_back(use_exp ? expv : model(row, int'(ph)));
            tag_q.push_back(tag);
            acc_q.push_back(cyc);
        end
        if (out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                total++;
                bad++;
                $display("FAIL R7 unexpected output got=%h exp=none", out_pixels);
            end else begin
                logic [OUT_W-1:0] e;
                string tg;
                int ac;
                e  = exp_q.pop_front();
                tg = tag_q.pop_front();
                ac = acc_q.pop_front();
                check_vec(tg, out_pixels, e);
                last_lat       = cyc - ac;
                last_take_cyc  = cyc;
                last_take_data = out_pixels;
            end
        end
        hold_pend = out_valid && !out_ready;
        hold_data = out_pixels;
    endtask

    task automatic feed(logic [IN_W-1:0] row, logic [3:0] ph, string tag);
        step(1'b1, row, ph, 1'b1, tag, 1'b0, '0);
    endtask

    task automatic drain();
        for (int i = 0; i < 8; i++)
            step(1'b0, '0, 4'd0, 1'b1, "", 1'b0, '0);
    endtask

    initial begin
        #(4 * 100000);
        total++;
        bad++;
        $display("FAIL watchdog expired got=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [IN_W-1:0] row;
        int first_acc;
        int accepted;
        void'($urandom(32'd2024));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #0.5;
        check_int("R1 out_valid after reset", int'(out_valid), 0);
        check_int("R1 in_ready after reset", int'(in_ready), 1);

        // R8 latency and R9 copy
        row = gen_row();
        feed(row, 4'd0, "R9 identity row");
        drain();
        check_int("R8 latency", last_lat, 3);
        check_vec("R9 copy of pixels 3..10", last_take_data, row[24 +: OUT_W]);

        for (int i = 0; i < 6; i++) feed(gen_row(), 4'd0, "R9 identity");
        drain();

        // R5 flat rows across all phases
        for (int p = 0; p < 16; p++) begin
            logic [7:0] v;
            step(1'b1, {15{8'h00}}, 4'(p), 1'b1, "R5 flat zero", 1'b1, {8{8'h00}});
            step(1'b1, {15{8'hFF}}, 4'(p), 1'b1, "R5 flat full", 1'b1, {8{8'hFF}});
            v = 8'($urandom);
            step(1'b1, {15{v}}, 4'(p), 1'b1, "R5 flat random", 1'b1, {8{v}});
        end
        drain();

        // R4 clamp: positive spike on the centre pair, negative on side lobes
        row = '0;
        row[3*8 +: 8] = 8'hFF;
        row[4*8 +: 8] = 8'hFF;
        feed(row, 4'd8, "R4 clamp high");
        drain();
        check_int("R4 column 0 saturates high", int'(last_take_data[7:0]), 255);
        row = '0;
        row[2*8 +: 8] = 8'hFF;
        row[5*8 +: 8] = 8'hFF;
        feed(row, 4'd8, "R4 clamp low");
        drain();
        check_int("R4 column 0 saturates low", int'(last_take_data[7:0]), 0);

        // R3 exact half rounds up: 8*8 = 64 -> 1
        row = '0;
        row[4*8 +: 8] = 8'd8;
        feed(row, 4'd1, "R3 half rounding");
        drain();
        check_int("R3 column 0 rounds half up", int'(last_take_data[7:0]), 1);

        // R8 throughput: 16 back-to-back rows
        accepted = 0;
        first_acc = 0;
        for (int i = 0; i < 16; i++) begin
            row = gen_row();
            feed(row, 4'(i), "R8 burst");
            if (in_ready) accepted++;
            if (i == 0) first_acc = cyc;
        end
        drain();
        check_int("R8 burst all accepted", accepted, 16);
        check_int("R8 burst last output cycle", last_take_cyc - first_acc, 18);

        // R2 and R7: random rows, phases and backpressure
        for (int i = 0; i < 3000; i++) begin
            logic iv, ordy;
            iv   = ($urandom % 4) != 0;
            ordy = ($urandom % 3) != 0;
            step(iv, gen_row(), 4'($urandom), ordy, "R2 random row", 1'b0, '0);
        end
        drain();
        check_int("R7 no row lost", exp_q.size(), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule